// File: doc/BRIEF.md
# Round-Robin Streaming Channel Multiplexer

This block merges a parameterised number of identical valid/ready streaming inputs into one output stream. Each input carries a data beat made of several symbols, an optional channel number, an optional error field and optional packet delimiters: start, end and the count of unused symbols in the last beat. A round-robin scheduler gives the output to one input at a time. Every other input sees ready held low until its turn comes.

The scheduler works in one of two ways. In burst mode a grant covers at most a fixed number of transferred beats. It ends early when the granted input runs dry or delivers an end of packet. In packet mode a grant is held from the first beat of a packet to its last, so packets from different inputs never interleave. On its way out, each beat's channel field is widened by the index of the input that supplied it. A parameter selects whether that index goes above or below the incoming channel bits. Nothing is stored: the payload passes straight through from the granted input to the output within the same cycle.

Top module: `rr_stream_mux`

## Requirements
- R1: After reset, with no input valid, `out_valid` is low. The first grant goes to port 0 when every port requests.
- R2: When a grant ends, the next grant goes to the first requesting port after the last granted port in ascending, wrapping order. Ports that are not valid are skipped, and the switch takes no idle cycle.
- R3: Only the granted port sees `in_ready` high, and only while `out_ready` is high. Every other port sees `in_ready` low.
- R4: `out_valid`, `out_data`, `out_err`, `out_sop`, `out_eop` and `out_empty` equal the granted port's signals in the same cycle.
- R5: In burst mode (`PKT_SCHED`=0) a grant ends after `BURST_LEN` transferred beats. A beat counts only when valid and ready are both high, so stall cycles do not use up the burst.
- R6: In burst mode a grant ends when the granted port has valid low while `out_ready` is high. If valid is low while `out_ready` is low, the grant is kept.
- R7: With packet signals enabled (`HAS_PKT`=1), transferring a beat with end of packet set ends the grant.
- R8: In packet mode (`PKT_SCHED`=1) the grant changes only after an end-of-packet beat is transferred. Neither the burst length nor gaps in valid end it.
- R9: With `IDX_HIGH`=1, `out_chan` is {port index, input channel}. With `IDX_HIGH`=0 it is {input channel, port index}. The index field is clog2(`NUM_PORTS`) bits wide.
- R10: With `CH_BITS`=0 the input channel is ignored, and `out_chan` is exactly the port index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NUM_PORTS | Per-port valid |
| in_ready | output | NUM_PORTS | Per-port ready, high only for the granted port |
| in_data | input | NUM_PORTS*SYM_BITS*SYMS | Per-port data beats, port p at slice p |
| in_chan | input | NUM_PORTS*max(CH_BITS,1) | Per-port channel number |
| in_err | input | NUM_PORTS*max(ERR_BITS,1) | Per-port error field |
| in_sop | input | NUM_PORTS | Per-port start of packet |
| in_eop | input | NUM_PORTS | Per-port end of packet |
| in_empty | input | NUM_PORTS*EMW | Per-port count of unused symbols in the beat |
| out_valid | output | 1 | Merged valid |
| out_ready | input | 1 | Downstream ready |
| out_data | output | SYM_BITS*SYMS | Merged data beat |
| out_chan | output | CH_BITS+clog2(NUM_PORTS) | Input channel widened by the source port index |
| out_err | output | max(ERR_BITS,1) | Merged error field |
| out_sop | output | 1 | Merged start of packet |
| out_eop | output | 1 | Merged end of packet |
| out_empty | output | EMW | Merged empty count |

## Verification
The bench builds three instances of the block.

- **First instance:** four ports, 4-bit channels, 2-bit errors, packet signals on, burst mode with a 3-beat burst and the index placed high. It reaches burst expiry across a stall, early release on an end of packet, release on a dry input both with and without downstream ready, skipping of idle ports and wrap-around of the rotation.
- **Second instance:** three ports in packet mode with the index placed low. A port count that is not a power of two exercises rotation over a partly used index field. It also shows a packet held past the burst length and through a valid gap.
- **Third instance:** two ports, no channel input and a burst of one. It covers the index-only channel output and switching on every beat.

// File: rtl/rrmux_pkg.sv
package rrmux_pkg;

   localparam int MAX_PORTS = 16;
   localparam int MAX_SYMS  = 32;
   localparam int MAX_SBITS = 32;

   // a port width never drops below one bit, even for an absent field
   function automatic int at_least_one(input int w);
      return (w > 0) ? w : 1;
   endfunction

   // width of the empty-symbol count for a given number of symbols
   function automatic int empty_width(input int syms);
      return (syms > 1) ? $clog2(syms) : 1;
   endfunction

   // width of the port-index field
   function automatic int index_width(input int ports);
      return (ports > 1) ? $clog2(ports) : 1;
   endfunction

endpackage

// File: rtl/rrmux_sched.sv
module rrmux_sched
   import rrmux_pkg::*;
#(
   parameter int NUM_PORTS = 4,
   parameter int BURST_LEN = 4,
   parameter bit PKT_SCHED = 1'b0,
   parameter bit HAS_PKT   = 1'b1,
   localparam int IDXW = index_width(NUM_PORTS),
   localparam int CW   = $clog2(BURST_LEN + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_PORTS-1:0] req,
   input  logic                 dn_ready,
   input  logic                 sel_eop,
   output logic [IDXW-1:0]      sel
);

   logic [IDXW-1:0] grant_q;
   logic [IDXW-1:0] pick;
   logic            locked_q;
   logic            hold;
   logic            xfer;
   logic            burst_done;
   logic            rel;
   logic [CW-1:0]   cnt_q;
   logic [CW-1:0]   cnt_nxt;

   // rotation search starting one past the last granted port
   always_comb begin
      logic found;
      pick  = grant_q;
      found = 1'b0;
      for (int k = 1; k <= NUM_PORTS; k++) begin
         int j;
         j = (int'(grant_q) + k) % NUM_PORTS;
         if (!found && req[j]) begin
            pick  = IDXW'(j);
            found = 1'b1;
         end
      end
   end

   // a held grant survives a dry cycle only while downstream stalls,
   // or always when packets must stay whole
   always_comb begin
      hold = locked_q && (PKT_SCHED || req[grant_q] || !dn_ready);
      sel  = hold ? grant_q : pick;
      xfer = req[sel] && dn_ready;
   end

   generate
      if (PKT_SCHED) begin : g_pkt_mode
         always_comb begin
            cnt_nxt    = CW'(1);
            burst_done = 1'b0;
         end
      end else begin : g_burst_mode
         always_comb begin
            cnt_nxt    = hold ? (cnt_q + 1'b1) : CW'(1);
            burst_done = (cnt_nxt >= CW'(BURST_LEN));
         end
      end
   endgenerate

   always_comb rel = burst_done || (HAS_PKT && sel_eop);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grant_q  <= IDXW'(NUM_PORTS - 1);
         locked_q <= 1'b0;
         cnt_q    <= '0;
      end else if (xfer) begin
         grant_q  <= sel;
         cnt_q    <= cnt_nxt;
         locked_q <= !rel;
      end else if (!hold) begin
         locked_q <= 1'b0;
      end
   end

   // R5
   burst_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(BURST_LEN));

   // R6
   grant_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && !rel) |=> (sel == $past(sel)) ||
         (!PKT_SCHED && !req[$past(sel)] && dn_ready));

endmodule

// File: rtl/rrmux_lane_pick.sv
module rrmux_lane_pick
   import rrmux_pkg::*;
#(
   parameter int NUM_PORTS = 4,
   parameter int W         = 8,
   localparam int IDXW = index_width(NUM_PORTS)
) (
   input  logic [NUM_PORTS*W-1:0] bus,
   input  logic [IDXW-1:0]        sel,
   output logic [W-1:0]           lane
);

   always_comb begin
      lane = '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
         if (sel == IDXW'(p)) lane = bus[p*W +: W];
      end
   end

endmodule

// File: rtl/rrmux_chan_tag.sv
module rrmux_chan_tag
   import rrmux_pkg::*;
#(
   parameter int CH_BITS  = 4,
   parameter int IDXW     = 2,
   parameter bit IDX_HIGH = 1'b1,
   localparam int CHP = at_least_one(CH_BITS),
   localparam int OCW = CH_BITS + IDXW
) (
   input  logic [CHP-1:0]  chan_in,
   input  logic [IDXW-1:0] idx,
   output logic [OCW-1:0]  chan_out
);

   generate
      if (CH_BITS == 0) begin : g_idx_only
         logic unused_chan;
         assign unused_chan = ^chan_in;
         assign chan_out    = idx;
      end else if (IDX_HIGH) begin : g_idx_high
         assign chan_out = {idx, chan_in};
      end else begin : g_idx_low
         assign chan_out = {chan_in, idx};
      end
   endgenerate

endmodule

// File: rtl/rr_stream_mux.sv
module rr_stream_mux
   import rrmux_pkg::*;
#(
   parameter int NUM_PORTS = 4,
   parameter int SYM_BITS  = 8,
   parameter int SYMS      = 2,
   parameter int CH_BITS   = 4,
   parameter int ERR_BITS  = 2,
   parameter bit HAS_PKT   = 1'b1,
   parameter bit PKT_SCHED = 1'b0,
   parameter int BURST_LEN = 3,
   parameter bit IDX_HIGH  = 1'b1,
   localparam int DW   = SYM_BITS * SYMS,
   localparam int CHP  = at_least_one(CH_BITS),
   localparam int ERP  = at_least_one(ERR_BITS),
   localparam int EMW  = empty_width(SYMS),
   localparam int IDXW = index_width(NUM_PORTS),
   localparam int OCW  = CH_BITS + IDXW
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [NUM_PORTS-1:0]     in_valid,
   output logic [NUM_PORTS-1:0]     in_ready,
   input  logic [NUM_PORTS*DW-1:0]  in_data,
   input  logic [NUM_PORTS*CHP-1:0] in_chan,
   input  logic [NUM_PORTS*ERP-1:0] in_err,
   input  logic [NUM_PORTS-1:0]     in_sop,
   input  logic [NUM_PORTS-1:0]     in_eop,
   input  logic [NUM_PORTS*EMW-1:0] in_empty,
   output logic                     out_valid,
   input  logic                     out_ready,
   output logic [DW-1:0]            out_data,
   output logic [OCW-1:0]           out_chan,
   output logic [ERP-1:0]           out_err,
   output logic                     out_sop,
   output logic                     out_eop,
   output logic [EMW-1:0]           out_empty
);

   // elaboration-time legality
   if (NUM_PORTS < 2 || NUM_PORTS > MAX_PORTS) begin : g_bad_ports
      $error("rr_stream_mux: NUM_PORTS out of range 2..16");
   end
   if (SYMS < 1 || SYMS > MAX_SYMS) begin : g_bad_syms
      $error("rr_stream_mux: SYMS out of range 1..32");
   end
   if (SYM_BITS < 1 || SYM_BITS > MAX_SBITS) begin : g_bad_sbits
      $error("rr_stream_mux: SYM_BITS out of range 1..32");
   end
   if (CH_BITS < 0 || CH_BITS > 31) begin : g_bad_chan
      $error("rr_stream_mux: CH_BITS out of range 0..31");
   end
   if (BURST_LEN < 1) begin : g_bad_burst
      $error("rr_stream_mux: BURST_LEN must be at least 1");
   end
   if (PKT_SCHED && !HAS_PKT) begin : g_bad_mode
      $error("rr_stream_mux: packet scheduling needs packet signals");
   end

   logic [IDXW-1:0] sel;
   logic [CHP-1:0]  chan_pick;
   logic [ERP-1:0]  err_pick;
   logic            sop_pick;
   logic            eop_pick;
   logic [EMW-1:0]  empty_pick;
   logic            sel_eop;

   rrmux_sched #(
      .NUM_PORTS (NUM_PORTS),
      .BURST_LEN (BURST_LEN),
      .PKT_SCHED (PKT_SCHED),
      .HAS_PKT   (HAS_PKT)
   ) i_sched (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (in_valid),
      .dn_ready (out_ready),
      .sel_eop  (sel_eop),
      .sel      (sel)
   );

   rrmux_lane_pick #(.NUM_PORTS(NUM_PORTS), .W(DW)) i_pick_data (
      .bus (in_data), .sel (sel), .lane (out_data));
   rrmux_lane_pick #(.NUM_PORTS(NUM_PORTS), .W(CHP)) i_pick_chan (
      .bus (in_chan), .sel (sel), .lane (chan_pick));
   rrmux_lane_pick #(.NUM_PORTS(NUM_PORTS), .W(ERP)) i_pick_err (
      .bus (in_err), .sel (sel), .lane (err_pick));
   rrmux_lane_pick #(.NUM_PORTS(NUM_PORTS), .W(1)) i_pick_sop (
      .bus (in_sop), .sel (sel), .lane (sop_pick));
   rrmux_lane_pick #(.NUM_PORTS(NUM_PORTS), .W(1)) i_pick_eop (
      .bus (in_eop), .sel (sel), .lane (eop_pick));
   rrmux_lane_pick #(.NUM_PORTS(NUM_PORTS), .W(EMW)) i_pick_empty (
      .bus (in_empty), .sel (sel), .lane (empty_pick));

   rrmux_chan_tag #(
      .CH_BITS  (CH_BITS),
      .IDXW     (IDXW),
      .IDX_HIGH (IDX_HIGH)
   ) i_chan_tag (
      .chan_in  (chan_pick),
      .idx      (sel),
      .chan_out (out_chan)
   );

   assign out_valid = in_valid[sel];

   for (genvar g = 0; g < NUM_PORTS; g++) begin : g_ready
      assign in_ready[g] = out_ready && (sel == IDXW'(g));
   end

   if (ERR_BITS > 0) begin : g_err
      assign out_err = err_pick;
   end else begin : g_no_err
      assign out_err = '0;
   end

   if (HAS_PKT) begin : g_pkt
      assign out_sop   = sop_pick;
      assign out_eop   = eop_pick;
      assign out_empty = empty_pick;
      assign sel_eop   = eop_pick;
   end else begin : g_no_pkt
      assign out_sop   = 1'b0;
      assign out_eop   = 1'b0;
      assign out_empty = '0;
      assign sel_eop   = 1'b0;
   end

   // tracking for the packet-atomicity check
   logic            mid_pkt_q;
   logic [IDXW-1:0] last_src_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mid_pkt_q  <= 1'b0;
         last_src_q <= '0;
      end else if (out_valid && out_ready) begin
         mid_pkt_q  <= !out_eop;
         last_src_q <= sel;
      end
   end

   // R3
   ready_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(in_ready));

   // R3
   ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|in_ready) |-> out_ready);

   // R8
   pkt_atomic_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (PKT_SCHED && mid_pkt_q && out_valid && out_ready) |-> (sel == last_src_q));

endmodule

// File: tb/test_rr_stream_mux.sv
`timescale 1ns/1ps
module test_rr_stream_mux;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   task automatic chk(input bit ok, input string what, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   // ---------------- instance A: 4 ports, burst 3, index high ----------------
   logic [3:0]  a_valid, a_ready, a_sop, a_eop, a_empty;
   logic [63:0] a_data;
   logic [15:0] a_chan;
   logic [7:0]  a_err;
   logic        a_ovalid, a_oready, a_osop, a_oeop, a_oempty;
   logic [15:0] a_odata;
   logic [5:0]  a_ochan;
   logic [1:0]  a_oerr;

   rr_stream_mux #(.NUM_PORTS(4), .SYM_BITS(8), .SYMS(2), .CH_BITS(4),
      .ERR_BITS(2), .HAS_PKT(1'b1), .PKT_SCHED(1'b0), .BURST_LEN(3),
      .IDX_HIGH(1'b1)) i_rr_stream_mux (
      .clk(clk), .rst_n(rst_n), .in_valid(a_valid), .in_ready(a_ready),
      .in_data(a_data), .in_chan(a_chan), .in_err(a_err), .in_sop(a_sop),
      .in_eop(a_eop), .in_empty(a_empty), .out_valid(a_ovalid),
      .out_ready(a_oready), .out_data(a_odata), .out_chan(a_ochan),
      .out_err(a_oerr), .out_sop(a_osop), .out_eop(a_oeop),
      .out_empty(a_oempty));

   function automatic logic [15:0] a_dat(input int p);
      return 16'hC0DE ^ 16'(p * 16'h1111);
   endfunction
   function automatic logic [3:0] a_ch(input int p);
      return 4'(3 * p + 2);
   endfunction

   // vector: valid[11:8] eop[7:4] ready[3] exp_valid[2] exp_idx[1:0]
   localparam logic [11:0] VEC [20] = '{
      {4'b1111, 4'b0000, 1'b1, 1'b1, 2'd0},
      {4'b1111, 4'b0000, 1'b1, 1'b1, 2'd0},
      {4'b1111, 4'b0000, 1'b1, 1'b1, 2'd0},
      {4'b1111, 4'b0000, 1'b1, 1'b1, 2'd1},
      {4'b1111, 4'b0000, 1'b0, 1'b1, 2'd1},
      {4'b1111, 4'b0000, 1'b1, 1'b1, 2'd1},
      {4'b1111, 4'b0000, 1'b1, 1'b1, 2'd1},
      {4'b1111, 4'b0000, 1'b1, 1'b1, 2'd2},
      {4'b1111, 4'b0100, 1'b1, 1'b1, 2'd2},
      {4'b0011, 4'b0000, 1'b1, 1'b1, 2'd0},
      {4'b0000, 4'b0000, 1'b1, 1'b0, 2'd0},
      {4'b1000, 4'b0000, 1'b1, 1'b1, 2'd3},
      {4'b1001, 4'b0000, 1'b0, 1'b1, 2'd3},
      {4'b0001, 4'b0000, 1'b0, 1'b0, 2'd3},
      {4'b0011, 4'b0000, 1'b1, 1'b1, 2'd0},
      {4'b0011, 4'b0000, 1'b1, 1'b1, 2'd0},
      {4'b0011, 4'b0000, 1'b1, 1'b1, 2'd0},
      {4'b0011, 4'b0000, 1'b1, 1'b1, 2'd1},
      {4'b1110, 4'b0000, 1'b1, 1'b1, 2'd1},
      {4'b1100, 4'b0000, 1'b1, 1'b1, 2'd2}
   };

   // ---------------- instance B: 3 ports, packet mode, index low -------------
   logic [2:0]  b_valid, b_ready, b_sop, b_eop, b_empty, b_err;
   logic [11:0] b_data;
   logic [5:0]  b_chan;
   logic        b_ovalid, b_oready, b_osop, b_oeop, b_oempty, b_oerr;
   logic [3:0]  b_odata, b_ochan;

   rr_stream_mux #(.NUM_PORTS(3), .SYM_BITS(4), .SYMS(1), .CH_BITS(2),
      .ERR_BITS(0), .HAS_PKT(1'b1), .PKT_SCHED(1'b1), .BURST_LEN(2),
      .IDX_HIGH(1'b0)) i_rr_stream_mux_pkt (
      .clk(clk), .rst_n(rst_n), .in_valid(b_valid), .in_ready(b_ready),
      .in_data(b_data), .in_chan(b_chan), .in_err(b_err), .in_sop(b_sop),
      .in_eop(b_eop), .in_empty(b_empty), .out_valid(b_ovalid),
      .out_ready(b_oready), .out_data(b_odata), .out_chan(b_ochan),
      .out_err(b_oerr), .out_sop(b_osop), .out_eop(b_oeop),
      .out_empty(b_oempty));

   // ---------------- instance C: 2 ports, no channel input, burst 1 ----------
   logic [1:0]  c_valid, c_ready, c_sop, c_eop, c_err, c_chan;
   logic [7:0]  c_data;
   logic [3:0]  c_empty;
   logic        c_ovalid, c_oready, c_osop, c_oeop, c_oerr, c_ochan;
   logic [3:0]  c_odata;
   logic [1:0]  c_oempty;

   rr_stream_mux #(.NUM_PORTS(2), .SYM_BITS(1), .SYMS(4), .CH_BITS(0),
      .ERR_BITS(1), .HAS_PKT(1'b0), .PKT_SCHED(1'b0), .BURST_LEN(1),
      .IDX_HIGH(1'b1)) i_rr_stream_mux_nochan (
      .clk(clk), .rst_n(rst_n), .in_valid(c_valid), .in_ready(c_ready),
      .in_data(c_data), .in_chan(c_chan), .in_err(c_err), .in_sop(c_sop),
      .in_eop(c_eop), .in_empty(c_empty), .out_valid(c_ovalid),
      .out_ready(c_oready), .out_data(c_odata), .out_chan(c_ochan),
      .out_err(c_oerr), .out_sop(c_osop), .out_eop(c_oeop),
      .out_empty(c_oempty));

   task automatic b_step(input logic [2:0] v, input logic [2:0] e, input bit v_exp,
                         input int idx_exp, input string tag);
      @(negedge clk);
      b_valid  = v;
      b_eop    = e;
      b_oready = 1'b1;
      #2;
      chk(b_ovalid == v_exp, {tag, " out_valid"}, 64'(b_ovalid), 64'(v_exp));
      if (v_exp)
         chk(b_ochan == {2'(idx_exp + 1), 2'(idx_exp)}, {tag, " R9 chan"},
             64'(b_ochan), 64'({2'(idx_exp + 1), 2'(idx_exp)}));
   endtask

   initial begin
      a_valid = '0; a_eop = '0; a_oready = 1'b0;
      b_valid = '0; b_eop = '0; b_oready = 1'b0;
      c_valid = '0; c_oready = 1'b0;
      for (int p = 0; p < 4; p++) begin
         a_data[p*16 +: 16] = a_dat(p);
         a_chan[p*4 +: 4]   = a_ch(p);
         a_err[p*2 +: 2]    = 2'(p);
         a_sop[p]           = p[0];
         a_empty[p]         = ~p[0];
      end
      for (int p = 0; p < 3; p++) begin
         b_data[p*4 +: 4] = 4'(p + 9);
         b_chan[p*2 +: 2] = 2'(p + 1);
         b_sop[p]         = 1'b0;
         b_empty[p]       = 1'b0;
         b_err[p]         = 1'b0;
      end
      c_data = 8'h5A; c_chan = 2'b11; c_sop = '0; c_eop = '0; c_err = 2'b10;
      c_empty = 4'h6;

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #2;
      // R1: idle after reset
      chk(a_ovalid == 1'b0, "R1 idle out_valid A", 64'(a_ovalid), 64'd0);
      chk(b_ovalid == 1'b0, "R1 idle out_valid B", 64'(b_ovalid), 64'd0);

      // table walk on instance A (R1 R2 R5 R6 R7 in the grant index column)
      for (int i = 0; i < 20; i++) begin
         logic [3:0] v, e;
         bit rdy, ev;
         int ix;
         v   = VEC[i][11:8];
         e   = VEC[i][7:4];
         rdy = VEC[i][3];
         ev  = VEC[i][2];
         ix  = int'(VEC[i][1:0]);
         @(negedge clk);
         a_valid  = v;
         a_eop    = e;
         a_oready = rdy;
         #2;
         chk(a_ovalid == ev, $sformatf("R2 R5 R6 vector %0d out_valid", i),
             64'(a_ovalid), 64'(ev));
         if (ev) begin
            chk(a_ochan == {2'(ix), a_ch(ix)},
                $sformatf("R1 R2 R5 R6 R7 R9 vector %0d grant/chan", i),
                64'(a_ochan), 64'({2'(ix), a_ch(ix)}));
            chk(a_odata == a_dat(ix) && a_oerr == 2'(ix) && a_osop == ix[0] &&
                a_oempty == ~ix[0] && a_oeop == e[ix],
                $sformatf("R4 vector %0d payload", i), 64'(a_odata),
                64'(a_dat(ix)));
            chk(a_ready == (rdy ? 4'(1 << ix) : 4'd0),
                $sformatf("R3 vector %0d in_ready", i), 64'(a_ready),
                64'(rdy ? 4'(1 << ix) : 4'd0));
         end
      end
      @(negedge clk);
      a_valid = '0;

      // R8: packet on port 0 held past the burst length and through a gap
      b_step(3'b111, 3'b000, 1'b1, 0, "R8 beat1");
      b_step(3'b111, 3'b000, 1'b1, 0, "R8 beat2");
      b_step(3'b111, 3'b000, 1'b1, 0, "R8 beat3");
      b_step(3'b111, 3'b000, 1'b1, 0, "R8 beat4");
      b_step(3'b110, 3'b000, 1'b0, 0, "R8 gap");
      chk(b_ready[2:1] == 2'b00, "R8 R3 others blocked in gap",
          64'(b_ready), 64'd1);
      b_step(3'b111, 3'b001, 1'b1, 0, "R8 R7 last beat");
      chk(b_oeop == 1'b1, "R7 eop forwarded", 64'(b_oeop), 64'd1);
      b_step(3'b111, 3'b000, 1'b1, 1, "R8 R2 next packet");
      b_step(3'b111, 3'b010, 1'b1, 1, "R8 second last beat");
      b_step(3'b111, 3'b000, 1'b1, 2, "R2 R9 third port");
      chk(b_odata == 4'd11, "R4 data port 2", 64'(b_odata), 64'd11);
      @(negedge clk);
      b_valid = '0;

      // R10: index-only channel, burst of one alternates every beat
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         c_valid  = 2'b11;
         c_oready = 1'b1;
         #2;
         chk(c_ovalid == 1'b1 && c_ochan == k[0],
             $sformatf("R10 R5 beat %0d chan", k), 64'(c_ochan), 64'(k[0]));
         chk(c_oempty == 2'b00 && c_oeop == 1'b0 && c_oerr == c_err[k[0]],
             $sformatf("R4 beat %0d no-packet payload", k), 64'(c_oerr),
             64'(c_err[k[0]]));
      end
      @(negedge clk);
      c_valid = '0;

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule